// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This block is the issue-stage control of a statically scheduled pipeline with two slots. Every cycle the decoder offers one packet of two instruction descriptors. The first lane is reserved for arithmetic or branch work. The second lane is reserved for memory access. Each descriptor carries an operation class, two source register numbers and a destination register number.

The unit decides, cycle by cycle, what happens to the packet. The packet may issue whole, or issue with its memory lane deferred by one cycle. It may also be held in place so that the upstream stage presents it again. A packet that was packed wrongly is flagged, and the offending lane is issued as a bubble. Downstream logic sees two lane classes every cycle, and an idle lane reads as a nop. A branch flush input discards both the packet that is arriving and any memory operation that has been deferred.

Operation class codes: 0 = nop, 1 = arithmetic, 2 = branch, 3 = load, 4 = store. Codes 5 to 7 are illegal.

Register usage by class:

| Class | Reads | Writes |
|---|---|---|
| arithmetic | src1, src2 | dst |
| branch | src1, src2 | nothing |
| load | src1 (base) | dst |
| store | src1 (base), src2 (data) | nothing |
| nop | nothing | nothing |

Top module: `dih_issue_unit`

## Requirements
- R1: Lane A accepts classes 0, 1 and 2, and lane B accepts classes 0, 3 and 4. Any other code in a lane makes `pack_err` high in the cycle the packet is accepted, and that lane issues as a nop (lane class 0, issue flag low).
- R2: Suppose lane A holds an arithmetic op with a nonzero dst, and lane B reads that dst. Then lane A issues alone and the packet is accepted. In the next cycle lane B issues alone while `stall` is high.
- R3: Suppose the previous cycle issued a load in lane B with a nonzero dst, and either lane of the current packet reads that register. Then `stall` is high, neither lane issues, and the packet is retried in the following cycle without that hazard.
- R4: Register 0 never creates a dependency, neither for the split in R2 nor for the stall in R3.
- R5: An arithmetic result issued in the previous cycle may be read by either lane of the next packet without a stall or a split.
- R6: While `flush` is high, nothing issues, `stall` is low, `pack_err` is low and the counter does not move. A deferred lane-B op and any pending load hazard are discarded.
- R7: `lane_a_cls` and `lane_b_cls` show the class being issued in each lane, and read 0 (nop) whenever the matching issue flag is low.
- R8: `pkt_count` increments by one for every packet that is accepted, that is when `pkt_valid` is high, `stall` is low and `flush` is low. A split packet counts once.
- R9: After reset, with no packet offered, all issue flags, `stall`, `pack_err` and `pkt_count` are zero.
- R10: While `stall` is high the offered packet is not consumed and `pack_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Branch flush, kills the arriving and deferred work |
| pkt_valid | input | 1 | A packet is offered this cycle |
| a_cls | input | 3 | Lane A operation class |
| a_src1 | input | 5 | Lane A first source register |
| a_src2 | input | 5 | Lane A second source register |
| a_dst | input | 5 | Lane A destination register |
| b_cls | input | 3 | Lane B operation class |
| b_src1 | input | 5 | Lane B base register |
| b_src2 | input | 5 | Lane B store-data register |
| b_dst | input | 5 | Lane B load destination |
| issue_a | output | 1 | Lane A issues a real operation |
| issue_b | output | 1 | Lane B issues a real operation |
| lane_a_cls | output | 3 | Class issued in lane A, nop when idle |
| lane_b_cls | output | 3 | Class issued in lane B, nop when idle |
| stall | output | 1 | Offered packet not consumed, upstream must hold it |
| pack_err | output | 1 | Accepted packet had a wrongly typed lane |
| pkt_count | output | 16 | Number of packets accepted |

## Verification
The assertions assume that upstream honours `stall`. While `stall` is high, the same packet must stay on the inputs. The assertions also assume that `flush` may come in any cycle, including a deferred-issue cycle. The stimulus keeps to this contract because it re-presents the stalled packet unchanged and only draws a fresh random packet once `stall` has dropped. Register numbers come from a small range that includes register 0, so that dependencies, load hazards and the register-0 exemption all arise often.

// File: rtl/dih_pkg.sv
package dih_pkg;

    localparam int REG_W = 5;
    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] OP_NOP = 3'd0;
    localparam logic [CLS_W-1:0] OP_ALU = 3'd1;
    localparam logic [CLS_W-1:0] OP_BR  = 3'd2;
    localparam logic [CLS_W-1:0] OP_LD  = 3'd3;
    localparam logic [CLS_W-1:0] OP_ST  = 3'd4;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        logic [REG_W-1:0] dst;
    } slot_t;

    localparam slot_t SLOT_NOP = '{cls: OP_NOP, src1: '0, src2: '0, dst: '0};

    // true when the slot reads register r (register 0 never counts)
    function automatic logic slot_reads(slot_t s, logic [REG_W-1:0] r);
        logic hit;
        hit = 1'b0;
        if (r != '0) begin
            case (s.cls)
                OP_ALU, OP_BR, OP_ST: hit = (s.src1 == r) || (s.src2 == r);
                OP_LD:                hit = (s.src1 == r);
                default:              hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

    // register written by the slot, zero when it writes nothing
    function automatic logic [REG_W-1:0] slot_writes(slot_t s);
        logic [REG_W-1:0] w;
        case (s.cls)
            OP_ALU, OP_LD: w = s.dst;
            default:       w = '0;
        endcase
        return w;
    endfunction

    function automatic logic class_ok(logic [CLS_W-1:0] c, bit mem_lane);
        logic ok;
        if (c == OP_NOP)  ok = 1'b1;
        else if (mem_lane) ok = (c == OP_LD) || (c == OP_ST);
        else               ok = (c == OP_ALU) || (c == OP_BR);
        return ok;
    endfunction

endpackage

// File: rtl/dih_slot_filter.sv
module dih_slot_filter
    import dih_pkg::*;
#(
    parameter bit MEM_LANE = 1'b0
) (
    input  slot_t raw,
    output slot_t clean,
    output logic  bad
);
    always_comb begin
        bad   = !class_ok(raw.cls, MEM_LANE);
        clean = bad ? SLOT_NOP : raw;
    end
endmodule

// File: rtl/dih_hazard_detect.sv
module dih_hazard_detect
    import dih_pkg::*;
(
    input  slot_t            sa,
    input  slot_t            sb,
    input  logic [REG_W-1:0] load_reg,
    output logic             load_use,
    output logic             intra_dep
);
    logic [REG_W-1:0] a_wr;

    always_comb begin
        a_wr      = slot_writes(sa);
        load_use  = slot_reads(sa, load_reg) || slot_reads(sb, load_reg);
        intra_dep = slot_reads(sb, a_wr);
    end
endmodule

// File: rtl/dih_issue_ctrl.sv
module dih_issue_ctrl
    import dih_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             pkt_valid,
    input  slot_t            sa,
    input  slot_t            sb,
    input  logic             bad_a,
    input  logic             bad_b,
    input  logic             load_use,
    input  logic             intra_dep,
    output logic [REG_W-1:0] load_reg,
    output logic             hold_q,
    output logic             issue_a,
    output logic             issue_b,
    output logic [CLS_W-1:0] lane_a_cls,
    output logic [CLS_W-1:0] lane_b_cls,
    output logic             stall,
    output logic             pack_err,
    output logic [CNT_W-1:0] pkt_count
);
    slot_t            held_b;
    slot_t            out_b;
    logic             accept;
    logic             defer_b;
    logic [REG_W-1:0] next_load;

    always_comb begin
        accept   = 1'b0;
        defer_b  = 1'b0;
        issue_a  = 1'b0;
        issue_b  = 1'b0;
        stall    = 1'b0;
        pack_err = 1'b0;
        out_b    = SLOT_NOP;
        if (flush) begin
            accept = 1'b0;
        end else if (hold_q) begin
            issue_b = 1'b1;
            out_b   = held_b;
            stall   = 1'b1;
        end else if (pkt_valid) begin
            if (load_use) begin
                stall = 1'b1;
            end else begin
                accept   = 1'b1;
                pack_err = bad_a || bad_b;
                issue_a  = (sa.cls != OP_NOP);
                if (intra_dep) begin
                    defer_b = 1'b1;
                end else begin
                    issue_b = (sb.cls != OP_NOP);
                    out_b   = sb;
                end
            end
        end
        lane_a_cls = issue_a ? sa.cls : OP_NOP;
        lane_b_cls = issue_b ? out_b.cls : OP_NOP;
        next_load  = (issue_b && out_b.cls == OP_LD) ? out_b.dst : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            held_b    <= SLOT_NOP;
            load_reg  <= '0;
            pkt_count <= '0;
        end else begin
            hold_q   <= defer_b;
            if (defer_b) held_b <= sb;
            load_reg <= flush ? '0 : next_load;
            if (accept) pkt_count <= pkt_count + 1'b1;
        end
    end
endmodule

// File: rtl/dih_issue_unit.sv
module dih_issue_unit
    import dih_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     pkt_valid,
    input  logic [dih_pkg::CLS_W-1:0] a_cls,
    input  logic [dih_pkg::REG_W-1:0] a_src1,
    input  logic [dih_pkg::REG_W-1:0] a_src2,
    input  logic [dih_pkg::REG_W-1:0] a_dst,
    input  logic [dih_pkg::CLS_W-1:0] b_cls,
    input  logic [dih_pkg::REG_W-1:0] b_src1,
    input  logic [dih_pkg::REG_W-1:0] b_src2,
    input  logic [dih_pkg::REG_W-1:0] b_dst,
    output logic                     issue_a,
    output logic                     issue_b,
    output logic [dih_pkg::CLS_W-1:0] lane_a_cls,
    output logic [dih_pkg::CLS_W-1:0] lane_b_cls,
    output logic                     stall,
    output logic                     pack_err,
    output logic [CNT_W-1:0]         pkt_count
);
    localparam int NLANE = 2;

    slot_t            raw   [NLANE];
    slot_t            clean [NLANE];
    logic [NLANE-1:0] bad;
    logic [REG_W-1:0] load_reg;
    logic             hold_q;
    logic             load_use;
    logic             intra_dep;

    always_comb begin
        raw[0] = '{cls: a_cls, src1: a_src1, src2: a_src2, dst: a_dst};
        raw[1] = '{cls: b_cls, src1: b_src1, src2: b_src2, dst: b_dst};
    end

    // lane 0 takes arithmetic/branch work, lane 1 takes memory access
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        dih_slot_filter #(.MEM_LANE(g == 1)) u_filt (
            .raw   (raw[g]),
            .clean (clean[g]),
            .bad   (bad[g])
        );
    end

    dih_hazard_detect u_haz (
        .sa        (clean[0]),
        .sb        (clean[1]),
        .load_reg  (load_reg),
        .load_use  (load_use),
        .intra_dep (intra_dep)
    );

    dih_issue_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .pkt_valid  (pkt_valid),
        .sa         (clean[0]),
        .sb         (clean[1]),
        .bad_a      (bad[0]),
        .bad_b      (bad[1]),
        .load_use   (load_use),
        .intra_dep  (intra_dep),
        .load_reg   (load_reg),
        .hold_q     (hold_q),
        .issue_a    (issue_a),
        .issue_b    (issue_b),
        .lane_a_cls (lane_a_cls),
        .lane_b_cls (lane_b_cls),
        .stall      (stall),
        .pack_err   (pack_err),
        .pkt_count  (pkt_count)
    );
endmodule

// File: rtl/dih_checker.sv
module dih_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             pkt_valid,
    input logic             hold_q,
    input logic             issue_a,
    input logic             issue_b,
    input logic [2:0]       lane_a_cls,
    input logic [2:0]       lane_b_cls,
    input logic             stall,
    input logic             pack_err,
    input logic [CNT_W-1:0] pkt_count
);
    // R2
    deferred_b_issues_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !flush) |-> (issue_b && !issue_a && stall));

    // R6
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!issue_a && !issue_b && !stall && !pack_err));

    // R7
    idle_lane_nop_chk: assert property (@(posedge clk) disable iff (rst)
        ((!issue_a -> lane_a_cls == 3'd0) && (!issue_b -> lane_b_cls == 3'd0)));

    // R10
    stall_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!pack_err && !issue_a));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !stall && !flush) |=> (pkt_count == $past(pkt_count) + 1'b1));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && !stall && !flush) |=> $stable(pkt_count));
endmodule

bind dih_issue_unit dih_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .pkt_valid  (pkt_valid),
    .hold_q     (hold_q),
    .issue_a    (issue_a),
    .issue_b    (issue_b),
    .lane_a_cls (lane_a_cls),
    .lane_b_cls (lane_b_cls),
    .stall      (stall),
    .pack_err   (pack_err),
    .pkt_count  (pkt_count)
);

// File: tb/sim_dih_issue_unit.sv
`timescale 1ns/1ps
module sim_dih_issue_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic pkt_valid = 1'b0;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic [4:0] a_src1 = '0, a_src2 = '0, a_dst = '0;
    logic [4:0] b_src1 = '0, b_src2 = '0, b_dst = '0;
    logic issue_a, issue_b, stall, pack_err;
    logic [2:0] lane_a_cls, lane_b_cls;
    logic [15:0] pkt_count;

    int checks = 0;
    int errors = 0;

    // reference state
    logic       m_hold = 1'b0;
    logic [2:0] m_hb_cls = '0;
    logic [4:0] m_hb_dst = '0;
    logic [4:0] m_ld = '0;
    logic [15:0] m_cnt = '0;
    logic       last_stall = 1'b0;

    always #10 clk = ~clk;

    dih_issue_unit u0 (
        .clk(clk), .rst(rst), .flush(flush), .pkt_valid(pkt_valid),
        .a_cls(a_cls), .a_src1(a_src1), .a_src2(a_src2), .a_dst(a_dst),
        .b_cls(b_cls), .b_src1(b_src1), .b_src2(b_src2), .b_dst(b_dst),
        .issue_a(issue_a), .issue_b(issue_b), .lane_a_cls(lane_a_cls),
        .lane_b_cls(lane_b_cls), .stall(stall), .pack_err(pack_err),
        .pkt_count(pkt_count)
    );

    function automatic logic rd_a(logic [2:0] c, logic [4:0] s1, logic [4:0] s2, logic [4:0] r);
        if (r == 0) return 1'b0;
        if (c == 1 || c == 2) return (s1 == r) || (s2 == r);
        return 1'b0;
    endfunction

    function automatic logic rd_b(logic [2:0] c, logic [4:0] s1, logic [4:0] s2, logic [4:0] r);
        if (r == 0) return 1'b0;
        if (c == 3) return s1 == r;
        if (c == 4) return (s1 == r) || (s2 == r);
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // compare outputs for the inputs now applied, then advance the model
    task automatic step(string tag_in);
        logic [2:0] ea, eb;
        logic e_ia, e_ib, e_st, e_pe, acc, defer, bad_a, bad_b, lu;
        logic [4:0] bdst, awr;
        string tag;
        tag = tag_in;
        ea = a_cls; eb = b_cls;
        bad_a = !(ea == 0 || ea == 1 || ea == 2);
        bad_b = !(eb == 0 || eb == 3 || eb == 4);
        if (bad_a) ea = 0;
        if (bad_b) eb = 0;
        e_ia = 0; e_ib = 0; e_st = 0; e_pe = 0; acc = 0; defer = 0;
        bdst = 0;
        awr = (ea == 1) ? a_dst : 5'd0;
        lu = rd_a(ea, a_src1, a_src2, m_ld) || rd_b(eb, b_src1, b_src2, m_ld);
        if (flush) begin
            if (tag == "") tag = "R6";
        end else if (m_hold) begin
            e_ib = 1; e_st = 1;
            if (tag == "") tag = "R2";
        end else if (pkt_valid) begin
            if (lu) begin
                e_st = 1;
                if (tag == "") tag = "R3";
            end else begin
                acc = 1; e_pe = bad_a || bad_b;
                e_ia = (ea != 0);
                if (rd_b(eb, b_src1, b_src2, awr)) defer = 1;
                else e_ib = (eb != 0);
                if (tag == "") tag = e_pe ? "R1" : (defer ? "R2" : "R8");
            end
        end
        if (tag == "") tag = "R7";
        #1;
        check(tag, {issue_a, issue_b, stall, pack_err, lane_a_cls, lane_b_cls, pkt_count},
              {e_ia, e_ib, e_st, e_pe,
               e_ia ? ea : 3'd0,
               e_ib ? (m_hold ? m_hb_cls : eb) : 3'd0, m_cnt});
        last_stall = stall;
        // model update at the coming edge
        if (!flush && m_hold && m_hb_cls == 3) bdst = m_hb_dst;
        else if (!flush && !m_hold && e_ib && eb == 3) bdst = b_dst;
        m_ld = flush ? 5'd0 : bdst;
        if (defer && !flush) begin m_hb_cls = eb; m_hb_dst = b_dst; end
        m_hold = defer && !flush;
        if (acc) m_cnt = m_cnt + 1;
        @(negedge clk);
    endtask

    task automatic put(logic v, logic [2:0] ac, logic [4:0] a1, logic [4:0] a2, logic [4:0] ad,
                       logic [2:0] bc, logic [4:0] b1, logic [4:0] b2, logic [4:0] bd);
        pkt_valid = v; a_cls = ac; a_src1 = a1; a_src2 = a2; a_dst = ad;
        b_cls = bc; b_src1 = b1; b_src2 = b2; b_dst = bd;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state with nothing offered
        step("R9");
        // R1: wrong classes in both lanes
        put(1, 3'd3, 1, 2, 3, 3'd1, 1, 2, 3);
        step("R1");
        put(1, 3'd6, 0, 0, 0, 3'd4, 1, 2, 0);
        step("R1");
        // R2: store base depends on same-packet ALU result
        put(1, 3'd1, 1, 2, 5, 3'd4, 5, 7, 0);
        step("R2");
        put(1, 3'd1, 2, 3, 4, 3'd0, 0, 0, 0);
        step("R2");
        step("R2");
        // R4: register 0 as producer and load target
        put(1, 3'd1, 1, 2, 0, 3'd3, 0, 0, 0);
        step("R4");
        put(1, 3'd2, 0, 0, 0, 3'd4, 0, 0, 0);
        step("R4");
        // R3: load to 6 then ALU reads 6
        put(1, 3'd0, 0, 0, 0, 3'd3, 1, 0, 6);
        step("R3");
        put(1, 3'd1, 6, 1, 7, 3'd6, 0, 0, 0);
        step("R10");
        step("R3");
        // R5: ALU writes 9, next packet reads 9 in both lanes
        put(1, 3'd1, 1, 1, 9, 3'd0, 0, 0, 0);
        step("R5");
        put(1, 3'd2, 9, 9, 0, 3'd3, 9, 0, 2);
        step("R5");
        // R6: flush during deferred issue
        put(1, 3'd1, 1, 2, 8, 3'd3, 8, 0, 4);
        step("R2");
        flush = 1;
        step("R6");
        flush = 0;
        // R6: flush clears load hazard
        put(1, 3'd0, 0, 0, 0, 3'd3, 1, 0, 11);
        step("R6");
        flush = 1; put(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6");
        flush = 0; put(1, 3'd1, 11, 0, 1, 3'd0, 0, 0, 0);
        step("R6");
        // R7: empty lane A
        put(1, 3'd0, 0, 0, 0, 3'd4, 1, 2, 0);
        step("R7");
        put(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R7");
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            flush = ($urandom % 16) == 0;
            if (!last_stall) begin
                logic [31:0] r;
                r = $urandom;
                put(($urandom % 8) != 0,
                    (r[3:0] == 0) ? 3'($urandom % 8) : 3'(r[4] ? 1 : (r[5] ? 2 : 0)),
                    5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
                    (r[9:6] == 0) ? 3'($urandom % 8) : 3'(r[10] ? 3 : (r[11] ? 4 : 0)),
                    5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
            end
            step("");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial void'($urandom(32'd7411));
endmodule